// File: doc/BRIEF.md
# Snooping Four-State Coherence Line Controller

This block holds the coherence state and tag of every line in a small direct-mapped private cache that sits on a shared bus. Each line is Modified, Exclusive, Shared or Invalid. The processor side presents one read or write request per cycle. The block answers hit or miss and issues the bus transaction the access needs: a read, a read-for-ownership or an invalidate. A line-fill sharing indication from the other caches arrives together with the request. The snoop side presents transactions seen on the bus from other caches. The block answers with a shared indication, requests a write-back when it holds the only dirty copy, and moves the snooped line to its new state.

The data array, memory and bus arbitration are outside the block. Requests are taken at face value and completed in the same cycle. A write-through inner cache that does not watch the bus receives an invalidate pulse for every line that is taken away by a snoop or by an eviction. When a snoop and a processor request hit the same index in one cycle, the snoop is applied first and the processor request is judged against the result.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and every output is low, so the first processor access to any index misses.
- R2: All outputs are registered and appear one cycle after the request. Bus command code 1 means read, 2 means read-for-ownership and 3 means invalidate. A read miss issues code 1 and installs the line Exclusive when the sharing input is low, or Shared when it is high. The bus address outputs carry the request's index and tag while a command is valid and are zero otherwise.
- R3: A read hit reports a hit, issues no bus command and leaves the state unchanged.
- R4: A write hit on an Exclusive line moves it to Modified silently. A write hit on a Modified line leaves it Modified with no bus command.
- R5: A write hit on a Shared line moves it to Modified and issues an invalidate (code 3).
- R6: A write miss issues a read-for-ownership (code 2) and installs the line Modified.
- R7: A snooped read that hits a valid line asserts the shared response and leaves the line Shared. When the line was Modified, the block also requests a write-back.
- R8: A snooped read-for-ownership or invalidate that hits a valid line makes it Invalid and asserts the shared response. A read-for-ownership that hits a Modified line also requests a write-back.
- R9: Every line made Invalid by a snoop produces a one-cycle inner invalidate pulse carrying that index.
- R10: A miss that displaces a valid line with another tag produces an inner eviction pulse with the old index. It requests a write-back with the old tag only when the displaced line was Modified. Displacing Exclusive or Shared lines needs no write-back.
- R11: When a snoop and a processor request target the same index in one cycle, the snoop takes effect first and the processor request is evaluated against the updated state.
- R12: A snoop whose tag differs from the stored tag, or that targets an Invalid line, produces no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request valid |
| cpu_we_i | input | 1 | Request is a write |
| cpu_idx_i | input | IDX_W | Request line index |
| cpu_tag_i | input | TAG_W | Request tag |
| fill_shared_i | input | 1 | Other caches hold the line being filled |
| snp_valid_i | input | 1 | Snooped transaction valid |
| snp_cmd_i | input | 2 | Snooped command (1 read, 2 read-for-ownership, 3 invalidate) |
| snp_idx_i | input | IDX_W | Snooped index |
| snp_tag_i | input | TAG_W | Snooped tag |
| cpu_hit_o | output | 1 | Request hit |
| cpu_miss_o | output | 1 | Request missed |
| bus_cmd_valid_o | output | 1 | Bus command issued |
| bus_cmd_o | output | 2 | Bus command code |
| bus_idx_o | output | IDX_W | Bus command index |
| bus_tag_o | output | TAG_W | Bus command tag |
| evict_wb_o | output | 1 | Write-back of displaced dirty line |
| evict_tag_o | output | TAG_W | Tag of displaced dirty line |
| inner_evict_inv_o | output | 1 | Inner invalidate due to eviction |
| inner_evict_idx_o | output | IDX_W | Index of evicted line |
| snp_shared_o | output | 1 | Snoop hit a valid line |
| snp_wb_o | output | 1 | Snoop requires write-back |
| inner_snp_inv_o | output | 1 | Inner invalidate due to snoop |
| inner_snp_idx_o | output | IDX_W | Index invalidated by snoop |

## Verification
The hardest case to reach is a snoop and a processor request meeting at the same index in one cycle while the line is in a state where the order matters. Examples are an invalidate arriving with a write to a Shared line, which must turn the write hit into a read-for-ownership miss, and a snooped read arriving with a write to an Exclusive line. Directed steps set up such a line, then launch both transactions in one cycle. A long pseudo-random sweep then uses only two tags over four indices, so collisions, evictions of dirty lines and same-index overlaps occur thousands of times. A reference model in the bench tracks each line and predicts every output.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RFO  = 2'd2,
    CMD_INV  = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ra_idx_i,
  output mesi_e            ra_st_o,
  output logic [TAG_W-1:0] ra_tag_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output mesi_e            rb_st_o,
  output logic [TAG_W-1:0] rb_tag_o,
  input  logic             wa_en_i,
  input  logic [IDX_W-1:0] wa_idx_i,
  input  mesi_e            wa_st_i,
  input  logic             wb_en_i,
  input  logic [IDX_W-1:0] wb_idx_i,
  input  mesi_e            wb_st_i,
  input  logic [TAG_W-1:0] wb_tag_i
);
  localparam int LINES = 1 << IDX_W;

  mesi_e            st_arr  [LINES];
  logic [TAG_W-1:0] tag_arr [LINES];

  // port b (processor) wins: it was evaluated against port a's result
  for (genvar g = 0; g < LINES; g++) begin : g_line
    mesi_e            st_q;
    logic [TAG_W-1:0] tag_q;
    logic             sel_a, sel_b;

    assign sel_a = wa_en_i && (wa_idx_i == IDX_W'(g));
    assign sel_b = wb_en_i && (wb_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= ST_I;
        tag_q <= '0;
      end else if (sel_b) begin
        st_q  <= wb_st_i;
        tag_q <= wb_tag_i;
      end else if (sel_a) begin
        st_q  <= wa_st_i;
      end
    end

    assign st_arr[g]  = st_q;
    assign tag_arr[g] = tag_q;
  end

  assign ra_st_o  = st_arr[ra_idx_i];
  assign ra_tag_o = tag_arr[ra_idx_i];
  assign rb_st_o  = st_arr[rb_idx_i];
  assign rb_tag_o = tag_arr[rb_idx_i];
endmodule

// File: rtl/mesi_snoop_eval.sv
module mesi_snoop_eval
  import mesi_pkg::*;
(
  input  logic     valid_i,
  input  bus_cmd_e cmd_i,
  input  mesi_e    st_i,
  input  logic     tag_match_i,
  output logic     hit_o,
  output logic     wr_en_o,
  output mesi_e    next_st_o,
  output logic     wb_o,
  output logic     inv_o
);
  logic h;

  always_comb begin
    h         = valid_i && (cmd_i != CMD_NONE) && (st_i != ST_I) && tag_match_i;
    hit_o     = h;
    wr_en_o   = h;
    next_st_o = st_i;
    wb_o      = 1'b0;
    inv_o     = 1'b0;
    if (h) begin
      unique case (cmd_i)
        CMD_RD: begin
          next_st_o = ST_S;
          wb_o      = (st_i == ST_M);
        end
        CMD_RFO: begin
          next_st_o = ST_I;
          wb_o      = (st_i == ST_M);
          inv_o     = 1'b1;
        end
        default: begin
          // invalidate from a writer that held Shared; no dirty data here
          next_st_o = ST_I;
          inv_o     = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/mesi_cpu_eval.sv
module mesi_cpu_eval
  import mesi_pkg::*;
(
  input  logic     req_i,
  input  logic     we_i,
  input  mesi_e    st_i,
  input  logic     tag_match_i,
  input  logic     shared_i,
  output logic     hit_o,
  output logic     miss_o,
  output bus_cmd_e cmd_o,
  output logic     wr_en_o,
  output mesi_e    next_st_o,
  output logic     evict_wb_o,
  output logic     evict_inv_o
);
  logic h;

  always_comb begin
    h           = req_i && (st_i != ST_I) && tag_match_i;
    hit_o       = h;
    miss_o      = req_i && !h;
    cmd_o       = CMD_NONE;
    wr_en_o     = 1'b0;
    next_st_o   = st_i;
    evict_wb_o  = 1'b0;
    evict_inv_o = 1'b0;
    if (h && we_i) begin
      wr_en_o   = 1'b1;
      next_st_o = ST_M;
      if (st_i == ST_S) cmd_o = CMD_INV;
    end else if (req_i && !h) begin
      wr_en_o     = 1'b1;
      evict_inv_o = (st_i != ST_I);
      evict_wb_o  = (st_i == ST_M);
      if (we_i) begin
        cmd_o     = CMD_RFO;
        next_st_o = ST_M;
      end else begin
        cmd_o     = CMD_RD;
        next_st_o = shared_i ? ST_S : ST_E;
      end
    end
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic             cpu_we_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic [TAG_W-1:0] cpu_tag_i,
  input  logic             fill_shared_i,
  input  logic             snp_valid_i,
  input  logic [1:0]       snp_cmd_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  output logic             cpu_hit_o,
  output logic             cpu_miss_o,
  output logic             bus_cmd_valid_o,
  output logic [1:0]       bus_cmd_o,
  output logic [IDX_W-1:0] bus_idx_o,
  output logic [TAG_W-1:0] bus_tag_o,
  output logic             evict_wb_o,
  output logic [TAG_W-1:0] evict_tag_o,
  output logic             inner_evict_inv_o,
  output logic [IDX_W-1:0] inner_evict_idx_o,
  output logic             snp_shared_o,
  output logic             snp_wb_o,
  output logic             inner_snp_inv_o,
  output logic [IDX_W-1:0] inner_snp_idx_o
);
  mesi_e            s_st, c_st_raw, c_st_eff, s_next, c_next;
  logic [TAG_W-1:0] s_tag, c_tag;
  logic             s_hit, s_wr, s_wb, s_inv, same_idx;
  logic             c_hit, c_miss, c_wr, c_ewb, c_einv;
  bus_cmd_e         c_cmd;

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_idx_i (snp_idx_i),
    .ra_st_o  (s_st),
    .ra_tag_o (s_tag),
    .rb_idx_i (cpu_idx_i),
    .rb_st_o  (c_st_raw),
    .rb_tag_o (c_tag),
    .wa_en_i  (s_wr),
    .wa_idx_i (snp_idx_i),
    .wa_st_i  (s_next),
    .wb_en_i  (c_wr),
    .wb_idx_i (cpu_idx_i),
    .wb_st_i  (c_next),
    .wb_tag_i (cpu_tag_i)
  );

  mesi_snoop_eval u_snoop (
    .valid_i     (snp_valid_i),
    .cmd_i       (bus_cmd_e'(snp_cmd_i)),
    .st_i        (s_st),
    .tag_match_i (s_tag == snp_tag_i),
    .hit_o       (s_hit),
    .wr_en_o     (s_wr),
    .next_st_o   (s_next),
    .wb_o        (s_wb),
    .inv_o       (s_inv)
  );

  // snoop ordered ahead of the local access on a shared index
  assign same_idx = s_wr && cpu_req_i && (snp_idx_i == cpu_idx_i);
  assign c_st_eff = same_idx ? s_next : c_st_raw;

  mesi_cpu_eval u_cpu (
    .req_i       (cpu_req_i),
    .we_i        (cpu_we_i),
    .st_i        (c_st_eff),
    .tag_match_i (c_tag == cpu_tag_i),
    .shared_i    (fill_shared_i),
    .hit_o       (c_hit),
    .miss_o      (c_miss),
    .cmd_o       (c_cmd),
    .wr_en_o     (c_wr),
    .next_st_o   (c_next),
    .evict_wb_o  (c_ewb),
    .evict_inv_o (c_einv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_hit_o         <= 1'b0;
      cpu_miss_o        <= 1'b0;
      bus_cmd_valid_o   <= 1'b0;
      bus_cmd_o         <= 2'd0;
      bus_idx_o         <= '0;
      bus_tag_o         <= '0;
      evict_wb_o        <= 1'b0;
      evict_tag_o       <= '0;
      inner_evict_inv_o <= 1'b0;
      inner_evict_idx_o <= '0;
      snp_shared_o      <= 1'b0;
      snp_wb_o          <= 1'b0;
      inner_snp_inv_o   <= 1'b0;
      inner_snp_idx_o   <= '0;
    end else begin
      cpu_hit_o         <= c_hit;
      cpu_miss_o        <= c_miss;
      bus_cmd_valid_o   <= (c_cmd != CMD_NONE);
      bus_cmd_o         <= c_cmd;
      bus_idx_o         <= (c_cmd != CMD_NONE) ? cpu_idx_i : '0;
      bus_tag_o         <= (c_cmd != CMD_NONE) ? cpu_tag_i : '0;
      evict_wb_o        <= c_ewb;
      evict_tag_o       <= c_ewb ? c_tag : '0;
      inner_evict_inv_o <= c_einv;
      inner_evict_idx_o <= c_einv ? cpu_idx_i : '0;
      snp_shared_o      <= s_hit;
      snp_wb_o          <= s_wb;
      inner_snp_inv_o   <= s_inv;
      inner_snp_idx_o   <= s_inv ? snp_idx_i : '0;
    end
  end
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_req_i,
  input logic             cpu_we_i,
  input logic [IDX_W-1:0] cpu_idx_i,
  input logic [TAG_W-1:0] cpu_tag_i,
  input logic             fill_shared_i,
  input logic             snp_valid_i,
  input logic [1:0]       snp_cmd_i,
  input logic [IDX_W-1:0] snp_idx_i,
  input logic [TAG_W-1:0] snp_tag_i,
  input logic             cpu_hit_o,
  input logic             cpu_miss_o,
  input logic             bus_cmd_valid_o,
  input logic [1:0]       bus_cmd_o,
  input logic [IDX_W-1:0] bus_idx_o,
  input logic [TAG_W-1:0] bus_tag_o,
  input logic             evict_wb_o,
  input logic [TAG_W-1:0] evict_tag_o,
  input logic             inner_evict_inv_o,
  input logic [IDX_W-1:0] inner_evict_idx_o,
  input logic             snp_shared_o,
  input logic             snp_wb_o,
  input logic             inner_snp_inv_o,
  input logic [IDX_W-1:0] inner_snp_idx_o
);
  AST_HIT_XOR_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_hit_o && cpu_miss_o)); // R3

  AST_RESP_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_hit_o || cpu_miss_o) |-> $past(cpu_req_i)); // R2

  AST_MISS_FETCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_miss_o |-> (bus_cmd_valid_o && (bus_cmd_o == 2'd1 || bus_cmd_o == 2'd2))); // R6

  AST_HIT_ONLY_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_hit_o && bus_cmd_valid_o) |-> (bus_cmd_o == 2'd3 && $past(cpu_we_i))); // R5

  AST_EVICT_WB_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_wb_o |-> (cpu_miss_o && inner_evict_inv_o)); // R10

  AST_SNP_WB_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_wb_o |-> (snp_shared_o && $past(snp_cmd_i) != 2'd3)); // R7

  AST_SNP_INV_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inner_snp_inv_o |-> (snp_shared_o && $past(snp_cmd_i) != 2'd1
                         && inner_snp_idx_o == $past(snp_idx_i))); // R9

  AST_SNP_RESP_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_shared_o |-> $past(snp_valid_i)); // R12
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns/1ps
module mesi_line_ctrl_test;
  localparam int IDX_W = 2;
  localparam int TAG_W = 3;
  localparam int LINES = 1 << IDX_W;
  // state codes in the model: 0 I, 1 S, 2 E, 3 M
  localparam int VW = 2 + 1 + 2 + IDX_W + TAG_W + 1 + TAG_W + 1 + IDX_W + 3 + IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             cpu_req = 0, cpu_we = 0, fill_sh = 0, snp_v = 0;
  logic [IDX_W-1:0] cpu_idx = 0, snp_idx = 0;
  logic [TAG_W-1:0] cpu_tag = 0, snp_tag = 0;
  logic [1:0]       snp_cmd = 0;

  logic             hit, miss, bv, ewb, einv, ssh, swb, sinv;
  logic [1:0]       bcmd;
  logic [IDX_W-1:0] bidx, eidx, sidx;
  logic [TAG_W-1:0] btag, etag;

  int total = 0, bad = 0;
  int m_st [LINES];
  int m_tag[LINES];

  mesi_line_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_idx_i(cpu_idx), .cpu_tag_i(cpu_tag),
    .fill_shared_i(fill_sh),
    .snp_valid_i(snp_v), .snp_cmd_i(snp_cmd), .snp_idx_i(snp_idx), .snp_tag_i(snp_tag),
    .cpu_hit_o(hit), .cpu_miss_o(miss), .bus_cmd_valid_o(bv), .bus_cmd_o(bcmd),
    .bus_idx_o(bidx), .bus_tag_o(btag), .evict_wb_o(ewb), .evict_tag_o(etag),
    .inner_evict_inv_o(einv), .inner_evict_idx_o(eidx),
    .snp_shared_o(ssh), .snp_wb_o(swb), .inner_snp_inv_o(sinv), .inner_snp_idx_o(sidx)
  );

  function automatic logic [VW-1:0] pack_act();
    return {hit, miss, bv, bcmd, bidx, btag, ewb, etag, einv, eidx, ssh, swb, sinv, sidx};
  endfunction

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, outputs registered at posedge, compare after it
  task automatic step(input string req, input logic cr, input logic cw, input int ci, input int ct,
                      input logic fs, input logic sv, input int sc, input int si, input int st);
    logic e_hit, e_miss, e_bv, e_ewb, e_einv, e_ssh, e_swb, e_sinv;
    logic [1:0] e_cmd;
    int e_bidx, e_btag, e_etag, e_eidx, e_sidx;
    int cs;
    e_hit = 0; e_miss = 0; e_bv = 0; e_ewb = 0; e_einv = 0; e_ssh = 0; e_swb = 0; e_sinv = 0;
    e_cmd = 0; e_bidx = 0; e_btag = 0; e_etag = 0; e_eidx = 0; e_sidx = 0;
    cpu_req = cr; cpu_we = cw; cpu_idx = ci[IDX_W-1:0]; cpu_tag = ct[TAG_W-1:0]; fill_sh = fs;
    snp_v = sv; snp_cmd = sc[1:0]; snp_idx = si[IDX_W-1:0]; snp_tag = st[TAG_W-1:0];
    // snoop applied to the model first
    if (sv && sc != 0 && m_st[si] != 0 && m_tag[si] == st) begin
      e_ssh = 1;
      if (sc == 1) begin
        e_swb = (m_st[si] == 3);
        m_st[si] = 1;
      end else begin
        e_swb = (sc == 2) && (m_st[si] == 3);
        e_sinv = 1; e_sidx = si;
        m_st[si] = 0;
      end
    end
    if (cr) begin
      cs = m_st[ci];
      if (cs != 0 && m_tag[ci] == ct) begin
        e_hit = 1;
        if (cw) begin
          if (cs == 1) begin e_bv = 1; e_cmd = 3; end
          m_st[ci] = 3;
        end
      end else begin
        e_miss = 1; e_bv = 1;
        if (cs != 0) begin e_einv = 1; e_eidx = ci; end
        if (cs == 3) begin e_ewb = 1; e_etag = m_tag[ci]; end
        e_cmd = cw ? 2'd2 : 2'd1;
        m_st[ci] = cw ? 3 : (fs ? 1 : 2);
        m_tag[ci] = ct;
      end
      if (e_bv) begin e_bidx = ci; e_btag = ct; end
    end
    @(posedge clk);
    #1;
    check(req, pack_act(),
          {e_hit, e_miss, e_bv, e_cmd, e_bidx[IDX_W-1:0], e_btag[TAG_W-1:0], e_ewb,
           e_etag[TAG_W-1:0], e_einv, e_eidx[IDX_W-1:0], e_ssh, e_swb, e_sinv,
           e_sidx[IDX_W-1:0]});
    cpu_req = 0; snp_v = 0;
    @(negedge clk);
  endtask

  task automatic cpu(input string req, input logic w, input int i, input int t, input logic fs);
    step(req, 1'b1, w, i, t, fs, 1'b0, 0, 0, 0);
  endtask

  task automatic snp(input string req, input int c, input int i, input int t);
    step(req, 1'b0, 1'b0, 0, 0, 1'b0, 1'b1, c, i, t);
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1", pack_act(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", pack_act(), '0);
    for (int i = 0; i < LINES; i++) cpu("R1", 1'b0, i, 0, 1'b0); // all miss, fill Exclusive (R2)
    cpu("R3", 1'b0, 0, 0, 1'b0);
    cpu("R3", 1'b0, 0, 0, 1'b0);
    snp("R7", 1, 0, 0);                 // E -> S
    cpu("R5", 1'b1, 0, 0, 1'b0);        // S -> M with invalidate
    snp("R7", 1, 0, 0);                 // M -> S, write-back
    cpu("R3", 1'b0, 0, 0, 1'b0);
    cpu("R4", 1'b1, 1, 0, 1'b0);        // E -> M silent
    cpu("R4", 1'b1, 1, 0, 1'b0);        // M stays M
    snp("R8", 2, 1, 0);                 // RFO on M: write-back and invalidate
    snp("R9", 3, 0, 0);                 // invalidate on S
    cpu("R2", 1'b0, 2, 1, 1'b1);        // displaces E, fills Shared
    cpu("R10", 1'b1, 3, 2, 1'b0);       // write miss displaces E, no write-back
    cpu("R6", 1'b1, 1, 5, 1'b0);        // write miss on Invalid line
    cpu("R10", 1'b0, 3, 3, 1'b0);       // displaces M, write-back old tag
    snp("R12", 1, 3, 0);                // tag mismatch
    snp("R12", 2, 0, 0);                // Invalid line
    cpu("R12", 1'b0, 3, 3, 1'b0);       // still Exclusive: hit
    cpu("R12", 1'b1, 3, 3, 1'b0);       // E -> M silent proves no change
    // same index: invalidate beats a write to Shared
    step("R11", 1'b1, 1'b1, 2, 1, 1'b0, 1'b1, 3, 2, 1);
    // same index: snooped read on M with a write hit that must now invalidate
    step("R11", 1'b1, 1'b1, 3, 3, 1'b0, 1'b1, 1, 3, 3);
    // same index: RFO from another cache with a local read
    step("R11", 1'b1, 1'b0, 1, 5, 1'b0, 1'b1, 2, 1, 5);
    for (int n = 0; n < 6000; n++) begin
      logic cr, cw, fs, sv;
      int ci, ct, sc, si, st;
      cr = ($urandom % 4) != 0; cw = $urandom % 2; fs = $urandom % 2;
      sv = ($urandom % 3) == 0;
      ci = $urandom % LINES; ct = $urandom % 2;
      sc = 1 + ($urandom % 3); si = (($urandom % 2) == 0) ? ci : ($urandom % LINES);
      st = $urandom % 2;
      if (cr && sv && ci == si) step("R11", cr, cw, ci, ct, fs, sv, sc, si, st);
      else if (sv)              step("R8", cr, cw, ci, ct, fs, sv, sc, si, st);
      else                      step("R2", cr, cw, ci, ct, fs, sv, sc, si, st);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule